// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block holds the time of day and the calendar date as seven BCD bytes and moves them forward by one second each time a single-cycle 1 Hz tick arrives. All carries (second to minute, minute to hour, hour to day and date, date to month, month to year) ripple through in the cycle of the tick. The new value appears on the snapshot output on the clock edge that samples the tick.

A host loads any one byte per cycle through a simple write port, selected by a field index. The snapshot output presents all seven bytes in parallel at all times. A shadow buffer or a bus front end can capture this output whenever it needs a coherent copy of the time.

The hours byte carries its own format. Bit 6 set selects 12-hour counting, and bit 5 is then the PM flag. The month byte carries a century flag in bit 7.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day 0x01, date 0x01, month 0x01 with century 0, and year 0x00.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. A tick at 0x59 returns the field to 0x00 and advances the next field by one.
- R3: With hours bit 6 clear, hours count 0x00 to 0x23. The tick that ends 23:59:59 gives 0x00 and starts a new day.
- R4: With hours bit 6 set, bits 4:0 count 1 to 12 in BCD and bit 5 is PM. 11 goes to 12 with bit 5 inverted, and 12 goes to 1 with bit 5 kept. The new day starts at 11 PM to 12 AM.
- R5: The day-of-week field advances once at each new day and cycles 1 to 7, going from 7 back to 1.
- R6: The date field wraps from the month's last day to 0x01 and advances the month. Months 0x04, 0x06, 0x09 and 0x11 have 30 days; months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12 have 31.
- R7: February (0x02) has 29 days when the BCD year is divisible by 4 (0x00, 0x04, ... 0x96) and 28 days otherwise.
- R8: At the end of December 31 the month (bits 4:0) goes from 0x12 to 0x01 and the year advances by one in BCD. The century bit is unchanged unless the year wraps.
- R9: When the year goes from 0x99 to 0x00, bit 7 of the month byte inverts, in both directions.
- R10: A write sets the field it addresses on the next clock edge, even when a tick arrives in the same cycle. Without a tick or a write, every field holds its value.
- R11: Field indexes are 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year. A write to index 7 changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, one per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Field index of the write |
| wr_data_i | input | 8 | BCD byte to load |
| snap_o | output | 56 | All fields; byte i (bits 8i+7..8i) is field index i |

## Verification
A wrong carry or wrap condition inside the block shows on the snapshot on the very edge that samples the offending tick. The fault appears as a field that fails to return to its minimum, a neighbour that fails to advance, or a PM or century bit left unchanged. Month-length and leap-year faults appear only on the single tick that ends the last day of a month, so each such boundary is preloaded to one second before the transition and checked one cycle after the tick. Write-priority faults show as a written byte overwritten by an increment in the cycle after the write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W  = 8;
  localparam int N_FIELDS = 7;
  localparam int IDX_W    = $clog2(N_FIELDS + 1);

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DAY   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 in BCD: even tens -> 0/4/8, odd tens -> 2/6
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr
  import rtc_pkg::*;
#(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] MAX_VAL = 8'h59,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] q_o,
  output logic       wrap_o
);
  logic [7:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= RST_VAL;
    else if (ld_i)  q_q <= ld_val_i;
    else if (inc_i) q_q <= (q_q == MAX_VAL) ? MIN_VAL : bcd_inc(q_q);
  end

  assign q_o    = q_q;
  assign wrap_o = inc_i && (q_q == MAX_VAL);

  assert_wrap_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && q_q == MAX_VAL) |=> (q_q == MIN_VAL));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(q_q));
  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_q == $past(ld_val_i)));
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] q_o,
  output logic       day_end_o
);
  logic [7:0] q_q, nxt, inc12, inc24;
  logic       mode12;

  assign mode12 = q_q[6];
  assign inc12  = bcd_inc({3'b000, q_q[4:0]});
  assign inc24  = bcd_inc({2'b00, q_q[5:0]});

  always_comb begin
    if (mode12) begin
      if (q_q[4:0] == 5'h12)      nxt = {q_q[7:5], 5'h01};
      else if (q_q[4:0] == 5'h11) nxt = {q_q[7:6], ~q_q[5], 5'h12};
      else                        nxt = {q_q[7:5], inc12[4:0]};
    end else begin
      if (q_q[5:0] == 6'h23)      nxt = {q_q[7:6], 6'h00};
      else                        nxt = {q_q[7:6], inc24[5:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 8'h00;
    else if (ld_i)  q_q <= ld_val_i;
    else if (inc_i) q_q <= nxt;
  end

  assign q_o       = q_q;
  assign day_end_o = inc_i && (mode12 ? (q_q[5] && q_q[4:0] == 5'h11)
                                      : (q_q[5:0] == 6'h23));

  assert_pm_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && q_q[6] && q_q[4:0] == 5'h11) |=> (q_q[5] != $past(q_q[5])));
  assert_noon_to_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && q_q[6] && q_q[4:0] == 5'h12) |=> (q_q[4:0] == 5'h01 && $stable(q_q[5])));
  assert_wrap24_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && !q_q[6] && q_q[5:0] == 6'h23) |=> (q_q[5:0] == 6'h00));
  assert_mode_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_q[6]));
endmodule

// File: rtl/rtc_date_ctr.sv
module rtc_date_ctr
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic [7:0] last_i,
  output logic [7:0] q_o,
  output logic       month_end_o
);
  logic [7:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 8'h01;
    else if (ld_i)  q_q <= ld_val_i;
    else if (inc_i) q_q <= (q_q == last_i) ? 8'h01 : bcd_inc(q_q);
  end

  assign q_o         = q_q;
  assign month_end_o = inc_i && (q_q == last_i);

  assert_date_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (month_end_o && !ld_i) |=> (q_q == 8'h01));
  assert_date_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(q_q));
endmodule

// File: rtl/rtc_month_ctr.sv
module rtc_month_ctr
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       cent_flip_i,
  output logic [7:0] q_o,
  output logic       year_end_o
);
  logic [7:0] q_q, m_inc;
  logic [4:0] m_nxt;

  assign m_inc = bcd_inc({3'b000, q_q[4:0]});
  assign m_nxt = (q_q[4:0] == 5'h12) ? 5'h01 : m_inc[4:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 8'h01;
    else if (ld_i)  q_q <= ld_val_i;
    else if (inc_i) q_q <= {q_q[7] ^ cent_flip_i, q_q[6:5], m_nxt};
  end

  assign q_o        = q_q;
  assign year_end_o = inc_i && (q_q[4:0] == 5'h12);

  assert_century_flip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cent_flip_i && !ld_i) |=> (q_q[7] != $past(q_q[7])));
  assert_century_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cent_flip_i && !ld_i) |=> $stable(q_q[7]));
  assert_dec_to_jan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (year_end_o && !ld_i) |=> (q_q[4:0] == 5'h01));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_addr_i,
  input  logic [FIELD_W-1:0]           wr_data_i,
  output logic [N_FIELDS*FIELD_W-1:0]  snap_o
);
  logic [N_FIELDS-1:0] ld;
  logic [7:0] sec_q, min_q, hour_q, day_q, date_q, month_q, year_q;
  logic       sec_wrap, min_wrap, day_end, month_end, year_end, year_wrap;
  logic       day_wrap_unused;
  logic [7:0] last_d;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_ld
    assign ld[i] = wr_en_i && (wr_addr_i == IDX_W'(i));
  end

  assign last_d = last_day(month_q[4:0], year_is_leap(year_q));

  rtc_bcd_ctr #(.MIN_VAL(8'h00), .MAX_VAL(8'h59), .RST_VAL(8'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick_i), .ld_i(ld[F_SEC]), .ld_val_i(wr_data_i),
    .q_o(sec_q), .wrap_o(sec_wrap));

  rtc_bcd_ctr #(.MIN_VAL(8'h00), .MAX_VAL(8'h59), .RST_VAL(8'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .ld_i(ld[F_MIN]), .ld_val_i(wr_data_i),
    .q_o(min_q), .wrap_o(min_wrap));

  rtc_hour_ctr u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap), .ld_i(ld[F_HOUR]), .ld_val_i(wr_data_i),
    .q_o(hour_q), .day_end_o(day_end));

  rtc_bcd_ctr #(.MIN_VAL(8'h01), .MAX_VAL(8'h07), .RST_VAL(8'h01)) u_day (
    .clk_i, .rst_ni, .inc_i(day_end), .ld_i(ld[F_DAY]), .ld_val_i(wr_data_i),
    .q_o(day_q), .wrap_o(day_wrap_unused));

  rtc_date_ctr u_date (
    .clk_i, .rst_ni, .inc_i(day_end), .ld_i(ld[F_DATE]), .ld_val_i(wr_data_i),
    .last_i(last_d), .q_o(date_q), .month_end_o(month_end));

  rtc_month_ctr u_month (
    .clk_i, .rst_ni, .inc_i(month_end), .ld_i(ld[F_MONTH]), .ld_val_i(wr_data_i),
    .cent_flip_i(year_wrap), .q_o(month_q), .year_end_o(year_end));

  rtc_bcd_ctr #(.MIN_VAL(8'h00), .MAX_VAL(8'h99), .RST_VAL(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(year_end), .ld_i(ld[F_YEAR]), .ld_val_i(wr_data_i),
    .q_o(year_q), .wrap_o(year_wrap));

  assign snap_o = {year_q, month_q, date_q, day_q, hour_q, min_q, sec_q};

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(snap_o));
  assert_bad_index_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && wr_en_i && wr_addr_i == IDX_W'(N_FIELDS)) |=> $stable(snap_o));
  assert_day_on_midnight_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!day_end && !ld[F_DAY]) |=> $stable(day_q));
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [55:0] snap;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .snap_o(snap));

  function automatic logic [7:0] fld(input int i);
    return snap[8*i +: 8];
  endfunction

  task automatic chk(input string req, input int i, input logic [7:0] exp);
    checks++;
    if (fld(i) !== exp) begin
      errors++;
      $display("FAIL %s field %0d: actual %h expected %h", req, i, fld(i), exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", 0, 8'h00); chk("R1", 1, 8'h00); chk("R1", 2, 8'h00);
    chk("R1", 3, 8'h01); chk("R1", 4, 8'h01); chk("R1", 5, 8'h01);
    chk("R1", 6, 8'h00);
  endtask

  task automatic t_sec_min;
    set_all(8'h58, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
    pulse; chk("R2", 0, 8'h59); chk("R2", 1, 8'h59);
    pulse; chk("R2", 0, 8'h00); chk("R2", 1, 8'h00); chk("R3", 2, 8'h06);
    wr(0, 8'h09); pulse; chk("R2", 0, 8'h10);
  endtask

  task automatic t_hold;
    repeat (5) @(negedge clk);
    chk("R10", 0, 8'h10); chk("R10", 1, 8'h00); chk("R10", 2, 8'h06);
  endtask

  task automatic t_24h;
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h21);
    pulse;
    chk("R3", 2, 8'h00); chk("R3", 1, 8'h00); chk("R5", 3, 8'h01);
    chk("R6", 4, 8'h16);
    set_all(8'h59, 8'h59, 8'h19, 8'h04, 8'h15, 8'h03, 8'h21);
    pulse; chk("R3", 2, 8'h20); chk("R5", 3, 8'h04);
  endtask

  task automatic t_12h;
    set_all(8'h59, 8'h59, 8'h51, 8'h03, 8'h10, 8'h06, 8'h24);
    pulse; chk("R4", 2, 8'h72); chk("R4", 3, 8'h03); chk("R4", 4, 8'h10);
    wr(0, 8'h59); wr(1, 8'h59);
    pulse; chk("R4", 2, 8'h61);
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h71);
    pulse; chk("R4", 2, 8'h52); chk("R5", 3, 8'h04); chk("R4", 4, 8'h11);
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h52);
    pulse; chk("R4", 2, 8'h41); chk("R4", 3, 8'h04);
  endtask

  task automatic t_month_len;
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
    pulse; chk("R6", 4, 8'h01); chk("R6", 5, 8'h05);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h21);
    pulse; chk("R6", 4, 8'h31); chk("R6", 5, 8'h05);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h21);
    pulse; chk("R6", 4, 8'h01); chk("R6", 5, 8'h12);
  endtask

  task automatic t_feb;
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    pulse; chk("R7", 4, 8'h29); chk("R7", 5, 8'h02);
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h23);
    pulse; chk("R7", 4, 8'h01); chk("R7", 5, 8'h03);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    pulse; chk("R7", 4, 8'h01); chk("R7", 5, 8'h03);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    pulse; chk("R7", 4, 8'h29);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    pulse; chk("R7", 4, 8'h01);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h96);
    pulse; chk("R7", 4, 8'h29);
  endtask

  task automatic t_new_year;
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h25);
    pulse; chk("R8", 5, 8'h01); chk("R8", 6, 8'h26); chk("R8", 4, 8'h01);
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h92, 8'h39);
    pulse; chk("R8", 5, 8'h81); chk("R8", 6, 8'h40);
  endtask

  task automatic t_century;
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    pulse; chk("R9", 5, 8'h81); chk("R9", 6, 8'h00);
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h92, 8'h99);
    pulse; chk("R9", 5, 8'h01); chk("R9", 6, 8'h00);
  endtask

  task automatic t_prio;
    set_all(8'h59, 8'h10, 8'h08, 8'h02, 8'h05, 8'h07, 8'h22);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R10", 1, 8'h33); chk("R10", 0, 8'h00);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h45;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R10", 0, 8'h45); chk("R10", 1, 8'h33);
  endtask

  task automatic t_bad_index;
    set_all(8'h12, 8'h34, 8'h56, 8'h06, 8'h21, 8'h09, 8'h77);
    wr(7, 8'hFF);
    repeat (2) @(negedge clk);
    chk("R11", 0, 8'h12); chk("R11", 1, 8'h34); chk("R11", 2, 8'h56);
    chk("R11", 3, 8'h06); chk("R11", 4, 8'h21); chk("R11", 5, 8'h09);
    chk("R11", 6, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sec_min;
    t_hold;
    t_24h;
    t_12h;
    t_month_len;
    t_feb;
    t_new_year;
    t_century;
    t_prio;
    t_bad_index;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule